// File: doc/BRIEF.md
# Serial packet selector

This block sits behind a bit-serial packet demultiplexer. It takes one packet bit per enabled clock and uses a start strobe to frame each packet of 751 bits. From the header it decides whether the packet should be acquired. Each subframe has its own filter setting, and the filter can match on the packet address with one of three qualifiers:
- any type byte, optionally narrowed by a data-group nibble;
- a small set of raw-class type bytes;
- a masked address-extension compare.

Packets in the last slot of a subframe are never taken.

For an accepted packet the block emits the stored payload as a byte stream. A CRC runs over the body without touching the data, and a completion pulse carries the CRC verdict and the uncorrectable-codeword count reported by the error-correction path. That path is modelled as a pass-through. When the subframe filter asks for half-length storage, the parity half of every 24-bit codeword is dropped from the stream.

Top module: `pkt_select`

## Requirements
- R1: A cycle with `bit_en`, `pkt_start` and `bit_in`=0 begins a packet, and the next 751 enabled bits are packet positions 0..750. Fields are sent least significant bit first: address at positions 0..9, type byte at 21..28, extension at 29..64.
- R2: Filter mode 0 accepts nothing. Mode 1 accepts on an address match; with `grp_en` set, bits 29..32 (low nibble of the byte after the type byte) must also equal `grp`.
- R3: Mode 2 accepts on an address match with type byte 0x00 or 0x3F. Such packets are always stored at full length, and their reported uncorrectable count is 0.
- R4: Mode 3 accepts on an address match where the 36-bit extension equals `ext_val` on every bit set in `ext_mask`.
- R5: The slot number becomes 1 on a start with `sf_first`, otherwise it rises by one per start and holds at 82. A packet in slot 82 or later is never accepted.
- R6: The filter setting used is the one for the subframe given by `sf_id` in the start cycle.
- R7: CRC-16 (polynomial 0x1021, preset 0xFFFF, MSB-first shift, no final inversion) runs over positions 31..750. `st_done` pulses for one cycle, and `st_crc_ok` is 1 when the remainder is zero; both appear in the cycle after the clock edge that takes position 750.
- R8: An accepted full-length packet yields 84 bytes from positions 79..750 in order, least significant bit first. The CRC result never changes them.
- R9: In half mode (`half`=1, mode 1 or 3), only the first 12 bits of each 24-bit group starting at position 79 are kept, giving 42 bytes.
- R10: A start strobe during a packet discards that packet (no `st_done`) and frames the new one.
- R11: Cycles without `bit_en` change nothing, even with `pkt_start` high.
- R12: `st_uncorr` gives the `fec_uncorr` value present with position 750.
- R13: After reset, `st_valid`, `st_done`, `st_crc_ok` and `st_uncorr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies the serial bit this cycle |
| bit_in | input | 1 | Serial packet bit |
| pkt_start | input | 1 | Marks the start bit of a packet slot |
| sf_first | input | 1 | With `pkt_start`: first slot of a subframe |
| sf_id | input | SF_W | Subframe index, sampled at start |
| flt_cfg | input | NUM_SF*CFG_W | Per-subframe filter settings, subframe 0 in the low slice |
| fec_uncorr | input | ERR_W | Uncorrectable codeword count from the correction path |
| st_valid | output | 1 | Store byte strobe |
| st_byte | output | 8 | Store byte |
| st_done | output | 1 | Accepted packet complete |
| st_crc_ok | output | 1 | CRC verdict, valid with `st_done` |
| st_uncorr | output | ERR_W | Uncorrectable count, valid with `st_done` |

## Verification
The accept decision is registered when position 65 is taken, which is well before the first store bit. Each store byte appears one cycle after the edge that takes its eighth kept bit. The bench collects bytes at the falling edge and compares the whole stream once the packet is over. The done pulse, CRC verdict and uncorrectable count are due exactly one cycle after the edge that takes bit 750. The bench samples them at the falling edge that follows that bit and checks again one cycle later that the pulse has cleared.

// File: rtl/pkt_pkg.sv
`timescale 1ns/1ps
// Shared packet layout constants, filter modes and the per-subframe filter setting.
package pkt_pkg;
    localparam int PKT_BITS  = 751;  // data bits after the start bit
    localparam int ADDR_W    = 10;
    localparam int TYPE_LSB  = 21;
    localparam int EXT_LSB   = 29;
    localparam int EXT_W     = 36;
    localparam int GRP_W     = 4;
    localparam int CRC_LSB   = 31;
    localparam int STORE_LSB = 79;
    localparam int HDR_BITS  = EXT_LSB + EXT_W;
    localparam int POS_W     = $clog2(PKT_BITS);

    typedef enum logic [1:0] {
        SEL_OFF  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_RAW  = 2'd2,
        SEL_EXT  = 2'd3
    } sel_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        sel_mode_e         mode;
        logic              grp_en;
        logic [GRP_W-1:0]  grp;
        logic [EXT_W-1:0]  ext_val;
        logic [EXT_W-1:0]  ext_mask;
        logic              half;
    } flt_cfg_t;

    localparam int CFG_W = $bits(flt_cfg_t);
endpackage

// File: rtl/pkt_filter.sv
`timescale 1ns/1ps
// Header filter: decides from a complete header whether one subframe setting
// selects the packet. Purely combinational.
// Assumes hdr[i] holds packet position i.
module pkt_filter
    import pkt_pkg::*;
(
    input  flt_cfg_t            cfg,
    input  logic [HDR_BITS-1:0] hdr,
    output logic                hit,
    output logic                raw
);
    logic       addr_ok;
    logic [7:0] type_b;
    logic [EXT_W-1:0] ext_b;

    // Field extraction from the header image.
    always_comb begin
        addr_ok = (hdr[ADDR_W-1:0] == cfg.addr);
        type_b  = hdr[TYPE_LSB +: 8];
        ext_b   = hdr[EXT_LSB +: EXT_W];
    end

    // Mode-dependent accept decision.
    always_comb begin
        raw = (cfg.mode == SEL_RAW);
        unique case (cfg.mode)
            SEL_ADDR: hit = addr_ok && (!cfg.grp_en || ext_b[GRP_W-1:0] == cfg.grp);
            SEL_RAW:  hit = addr_ok && (type_b == 8'h00 || type_b == 8'h3F);
            SEL_EXT:  hit = addr_ok && (((ext_b ^ cfg.ext_val) & cfg.ext_mask) == '0);
            default:  hit = 1'b0;
        endcase
    end

    // A disabled filter never selects (R2).
    always_comb begin
        assert_off_quiet_R2: assert (!(hit && cfg.mode == SEL_OFF))
            else $error("disabled filter selected a packet");
    end
endmodule

// File: rtl/pkt_crc16.sv
`timescale 1ns/1ps
// Bit-serial CRC-16, MSB-first shift, no final inversion.
// init has priority over en; crc_nxt is the value after absorbing din.
module pkt_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] SEED = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc_q,
    output logic [15:0] crc_nxt
);
    // Next-state of the shift register for one data bit.
    always_comb begin
        crc_nxt = {crc_q[14:0], 1'b0} ^ ((crc_q[15] ^ din) ? POLY : 16'h0000);
    end

    // Register update: preset at packet start, shift on body bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= SEED;
        else if (init)  crc_q <= SEED;
        else if (en)    crc_q <= crc_nxt;
    end

    assert_crc_preset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> crc_q == SEED);
endmodule

// File: rtl/pkt_packer.sv
`timescale 1ns/1ps
// Store byte packer: gathers kept bits LSB first into bytes.
// In half mode only the first KEEP bits of every GROUP-bit codeword are kept.
// Assumes at most one en per cycle and clr at every packet start.
module pkt_packer #(
    parameter int GROUP = 24,
    parameter int KEEP  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       half,
    input  logic       din,
    output logic       byte_valid,
    output logic [7:0] byte_q
);
    localparam int CNT_W = $clog2(GROUP);

    logic [CNT_W-1:0] grp_cnt;
    logic [2:0]       nbit;
    logic [7:0]       sr;
    logic             keep;

    // Keep decision for the current codeword bit.
    always_comb keep = !half || (grp_cnt < CNT_W'(KEEP));

    // Codeword position, bit gathering and byte emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_cnt    <= '0;
            nbit       <= '0;
            sr         <= '0;
            byte_valid <= 1'b0;
            byte_q     <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (clr) begin
                grp_cnt <= '0;
                nbit    <= '0;
            end else if (en) begin
                grp_cnt <= (grp_cnt == CNT_W'(GROUP-1)) ? '0 : grp_cnt + 1'b1;
                if (keep) begin
                    sr   <= {din, sr[7:1]};
                    nbit <= nbit + 1'b1;
                    if (nbit == 3'd7) begin
                        byte_valid <= 1'b1;
                        byte_q     <= {din, sr[7:1]};
                    end
                end
            end
        end
    end

    assert_byte_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
endmodule

// File: rtl/pkt_select.sv
`timescale 1ns/1ps
// Serial packet selector: frames packets from a start strobe with a zero
// start bit, counts subframe slots, filters each header with the setting of
// its subframe, runs the body CRC and streams the payload of accepted packets.
// Assumes bits arrive at most one per clock, qualified by bit_en.
module pkt_select
    import pkt_pkg::*;
#(
    parameter int NUM_SF  = 2,
    parameter int N_SLOTS = 82,
    parameter int ERR_W   = 4,
    parameter int SF_W    = (NUM_SF > 1) ? $clog2(NUM_SF) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_en,
    input  logic                    bit_in,
    input  logic                    pkt_start,
    input  logic                    sf_first,
    input  logic [SF_W-1:0]         sf_id,
    input  logic [NUM_SF*CFG_W-1:0] flt_cfg,
    input  logic [ERR_W-1:0]        fec_uncorr,
    output logic                    st_valid,
    output logic [7:0]              st_byte,
    output logic                    st_done,
    output logic                    st_crc_ok,
    output logic [ERR_W-1:0]        st_uncorr
);
    localparam int SLOT_W = $clog2(N_SLOTS + 1);

    logic                active;
    logic [POS_W-1:0]    pos;
    logic [SLOT_W-1:0]   slot;
    logic [SF_W-1:0]     sf_l;
    logic [HDR_BITS-1:0] hdr;
    logic                accept;
    logic                raw_l;
    logic                half_l;
    logic                start;
    logic                step;
    logic                last;
    logic [NUM_SF-1:0]   hit_v;
    logic [NUM_SF-1:0]   raw_v;
    logic [NUM_SF-1:0]   half_v;
    logic [15:0]         crc_q;
    logic [15:0]         crc_nxt;

    // Qualified strobes for framing.
    always_comb begin
        start = bit_en && pkt_start;
        step  = bit_en && !pkt_start && active;
        last  = step && (pos == POS_W'(PKT_BITS-1));
    end

    // One filter per subframe setting.
    for (genvar g = 0; g < NUM_SF; g++) begin : g_sf
        flt_cfg_t cfg_g;
        assign cfg_g     = flt_cfg[g*CFG_W +: CFG_W];
        assign half_v[g] = cfg_g.half;
        pkt_filter u_flt (
            .cfg (cfg_g),
            .hdr (hdr),
            .hit (hit_v[g]),
            .raw (raw_v[g])
        );
    end

    // Framing, bit position and subframe slot count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos    <= '0;
            slot   <= '0;
            sf_l   <= '0;
        end else if (start) begin
            active <= !bit_in;
            pos    <= '0;
            sf_l   <= sf_id;
            if (sf_first)                        slot <= SLOT_W'(1);
            else if (slot != SLOT_W'(N_SLOTS))   slot <= slot + 1'b1;
        end else if (step) begin
            if (last) active <= 1'b0;
            pos <= pos + 1'b1;
        end
    end

    // Header image: hdr[i] ends up holding position i.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  hdr <= '0;
        else if (start)                              hdr <= '0;
        else if (step && pos < POS_W'(HDR_BITS))     hdr <= {bit_in, hdr[HDR_BITS-1:1]};
    end

    // Accept decision, taken once the header is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept <= 1'b0;
            raw_l  <= 1'b0;
            half_l <= 1'b0;
        end else if (start) begin
            accept <= 1'b0;
        end else if (step && pos == POS_W'(HDR_BITS)) begin
            accept <= hit_v[sf_l] && (slot < SLOT_W'(N_SLOTS));
            raw_l  <= raw_v[sf_l];
            half_l <= half_v[sf_l] && !raw_v[sf_l];
        end
    end

    pkt_crc16 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (start),
        .en      (step && pos >= POS_W'(CRC_LSB)),
        .din     (bit_in),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    pkt_packer u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start),
        .en         (step && accept && pos >= POS_W'(STORE_LSB)),
        .half       (half_l),
        .din        (bit_in),
        .byte_valid (st_valid),
        .byte_q     (st_byte)
    );

    // Completion pulse with CRC verdict and correction count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done   <= 1'b0;
            st_crc_ok <= 1'b0;
            st_uncorr <= '0;
        end else begin
            st_done <= last && accept;
            if (last && accept) begin
                st_crc_ok <= (crc_nxt == 16'h0000);
                st_uncorr <= raw_l ? '0 : fec_uncorr;
            end
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |=> !st_done);
    assert_slot_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> slot < SLOT_W'(N_SLOTS));
    assert_done_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> $past(bit_en));
    assert_store_accepted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> accept);
endmodule

// File: tb/sim_pkt_select.sv
`timescale 1ns/1ps
// Bench for pkt_select: directed corner cases plus seeded random packets.
module sim_pkt_select;
    import pkt_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b1;
    logic pkt_start = 1'b0;
    logic sf_first = 1'b0;
    logic [0:0] sf_id = 1'b0;
    flt_cfg_t c0, c1;
    logic [2*CFG_W-1:0] cfgv;
    logic [3:0] fec_uncorr = 4'd0;
    logic st_valid, st_done, st_crc_ok;
    logic [7:0] st_byte;
    logic [3:0] st_uncorr;

    assign cfgv = {c1, c0};

    pkt_select u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .pkt_start(pkt_start), .sf_first(sf_first), .sf_id(sf_id),
        .flt_cfg(cfgv), .fec_uncorr(fec_uncorr),
        .st_valid(st_valid), .st_byte(st_byte), .st_done(st_done),
        .st_crc_ok(st_crc_ok), .st_uncorr(st_uncorr)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int done_cnt = 0;
    int exp_slot = 0;
    logic [7:0] got[$];
    logic [7:0] exp_q[$];

    // Byte and completion collector.
    always @(negedge clk) begin
        if (st_valid) got.push_back(st_byte);
        if (st_done)  done_cnt++;
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [750:0] build(input logic [9:0] a, input logic [7:0] t,
                                           input logic [35:0] e, input bit bad);
        logic [750:0] p;
        logic [15:0] c;
        for (int i = 0; i < 751; i++) begin
            logic [31:0] r;
            r = $urandom();
            p[i] = r[0];
        end
        for (int i = 0; i < 10; i++) p[i] = a[i];
        for (int i = 0; i < 8; i++)  p[21+i] = t[i];
        for (int i = 0; i < 36; i++) p[29+i] = e[i];
        c = 16'hFFFF;
        for (int i = 31; i < 735; i++) begin
            logic fb;
            fb = c[15] ^ p[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        for (int k = 0; k < 16; k++) p[735+k] = c[15-k];
        if (bad) p[500] = ~p[500];
        return p;
    endfunction

    function automatic void mk_exp(input logic [750:0] p, input bit half);
        logic [7:0] b;
        int n;
        b = 8'h00;
        n = 0;
        exp_q.delete();
        for (int q = 79; q < 751; q++) begin
            if (!half || ((q - 79) % 24) < 12) begin
                b[n] = p[q];
                n++;
                if (n == 8) begin
                    exp_q.push_back(b);
                    n = 0;
                end
            end
        end
    endfunction

    function automatic bit exp_hit(input flt_cfg_t c, input logic [750:0] p);
        logic [7:0] t;
        logic [35:0] e;
        bit a_ok;
        a_ok = (p[9:0] == c.addr);
        t = p[28:21];
        e = p[64:29];
        case (c.mode)
            SEL_ADDR: return a_ok && (!c.grp_en || e[3:0] == c.grp);
            SEL_RAW:  return a_ok && (t == 8'h00 || t == 8'h3F);
            SEL_EXT:  return a_ok && (((e ^ c.ext_val) & c.ext_mask) == 36'd0);
            default:  return 1'b0;
        endcase
    endfunction

    function automatic void slot_adv(input bit first);
        if (first) exp_slot = 1;
        else if (exp_slot < 82) exp_slot++;
    endfunction

    // Start strobe with a '1' start bit: counts a slot, frames nothing.
    task automatic tick_start(input bit first);
        @(negedge clk);
        bit_en = 1'b1; pkt_start = 1'b1; bit_in = 1'b1; sf_first = first;
        @(negedge clk);
        bit_en = 1'b0; pkt_start = 1'b0; sf_first = 1'b0;
        slot_adv(first);
    endtask

    // Start and the first n bits of a packet.
    task automatic send_part(input logic [750:0] p, input int sf, input bit first, input int n);
        @(negedge clk);
        bit_en = 1'b1; pkt_start = 1'b1; bit_in = 1'b0; sf_first = first; sf_id = 1'(sf);
        slot_adv(first);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pkt_start = 1'b0; sf_first = 1'b0; bit_en = 1'b1; bit_in = p[i];
        end
        @(negedge clk);
        bit_en = 1'b0; pkt_start = 1'b0; sf_first = 1'b0;
    endtask

    task automatic run_pkt(input logic [750:0] p, input int sf, input bit first, input bit gaps,
                           input bit exp_acc, input bit half, input logic [3:0] unc_in,
                           input bit exp_crc, input string req);
        logic d, ok;
        logic [3:0] u;
        int mism;
        fec_uncorr = unc_in;
        mk_exp(p, half);
        got.delete();
        done_cnt = 0;
        @(negedge clk);
        bit_en = 1'b1; pkt_start = 1'b1; bit_in = 1'b0; sf_first = first; sf_id = 1'(sf);
        slot_adv(first);
        for (int i = 0; i < 751; i++) begin
            @(negedge clk);
            pkt_start = 1'b0; sf_first = 1'b0;
            if (gaps) begin
                logic [31:0] r;
                r = $urandom();
                for (int k = 0; k < int'(r[1:0]); k++) begin
                    bit_en = 1'b0; pkt_start = r[2]; bit_in = r[3];
                    @(negedge clk);
                end
                pkt_start = 1'b0;
            end
            bit_en = 1'b1; bit_in = p[i];
        end
        @(negedge clk);
        bit_en = 1'b0;
        d = st_done; ok = st_crc_ok; u = st_uncorr;
        @(negedge clk);
        chk("R7", "done pulse cleared", longint'(st_done), 0);
        repeat (2) @(negedge clk);
        chk(req, "done after last bit", longint'(d), longint'(exp_acc));
        chk(req, "done count", done_cnt, exp_acc ? 1 : 0);
        if (exp_acc) begin
            chk("R7", "crc verdict", longint'(ok), longint'(exp_crc));
            chk("R12", "uncorrectable count", longint'(u),
                (half || exp_hit_raw) ? longint'(unc_exp) : longint'(unc_exp));
            chk(req, "byte count", got.size(), exp_q.size());
            mism = 0;
            for (int i = 0; i < got.size() && i < exp_q.size(); i++)
                if (got[i] != exp_q[i]) mism++;
            chk("R8", "byte mismatches", mism, 0);
        end else begin
            chk(req, "no store bytes", got.size(), 0);
        end
    endtask

    // Expected uncorrectable count for the next run_pkt (set by caller).
    logic [3:0] unc_exp = 4'd0;
    bit exp_hit_raw = 1'b0;

    function automatic flt_cfg_t base_cfg(input sel_mode_e m);
        flt_cfg_t c;
        c = '0;
        c.addr = 10'h2A5;
        c.mode = m;
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [750:0] p, p2;
        void'($urandom(32'd20240611));
        c0 = base_cfg(SEL_OFF);
        c1 = base_cfg(SEL_OFF);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "st_valid after reset", longint'(st_valid), 0);
        chk("R13", "st_done after reset", longint'(st_done), 0);
        chk("R13", "st_crc_ok after reset", longint'(st_crc_ok), 0);
        chk("R13", "st_uncorr after reset", longint'(st_uncorr), 0);

        // R1/R8: address mode, full length, good CRC.
        c0 = base_cfg(SEL_ADDR);
        p = build(10'h2A5, 8'h55, 36'h123456789, 1'b0);
        unc_exp = 4'd5;
        run_pkt(p, 0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5, 1'b1, "R1");
        chk("R8", "full length bytes", got.size(), 84);

        // R2: address mismatch; mode 0 never selects.
        p = build(10'h2A4, 8'h55, 36'h0, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, "R2");
        c0 = base_cfg(SEL_OFF);
        p = build(10'h2A5, 8'h55, 36'h0, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, "R2");

        // R2: data-group nibble match and mismatch.
        c0 = base_cfg(SEL_ADDR); c0.grp_en = 1'b1; c0.grp = 4'hB;
        p = build(10'h2A5, 8'h10, 36'h00000000B, 1'b0);
        unc_exp = 4'd2;
        run_pkt(p, 0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2, 1'b1, "R2");
        p = build(10'h2A5, 8'h10, 36'h00000000C, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 1'b1, "R2");

        // R3: raw class types 0x00 and 0x3F, other type rejected, half ignored.
        c0 = base_cfg(SEL_RAW); c0.half = 1'b1;
        unc_exp = 4'd0;
        p = build(10'h2A5, 8'h00, 36'h0, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd9, 1'b1, "R3");
        p = build(10'h2A5, 8'h3F, 36'h0, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7, 1'b1, "R3");
        p = build(10'h2A5, 8'h12, 36'h0, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7, 1'b1, "R3");

        // R4: masked extension compare.
        c0 = base_cfg(SEL_EXT); c0.ext_val = 36'hABCDE1234; c0.ext_mask = 36'hFFFF0FFFF;
        unc_exp = 4'd1;
        p = build(10'h2A5, 8'h77, 36'hABCD51234, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd1, 1'b1, "R4");
        p = build(10'h2A5, 8'h77, 36'hABCDE1235, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1, "R4");

        // R9: half-length storage.
        c0 = base_cfg(SEL_ADDR); c0.half = 1'b1;
        unc_exp = 4'd3;
        p = build(10'h2A5, 8'h01, 36'h0, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3, 1'b1, "R9");
        chk("R9", "half length bytes", got.size(), 42);

        // R7/R8: corrupted body fails CRC, data still delivered unchanged.
        c0 = base_cfg(SEL_ADDR);
        p = build(10'h2A5, 8'h01, 36'h0, 1'b1);
        run_pkt(p, 0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 1'b0, "R7");

        // R6: subframe 1 setting applies only when sf_id selects it.
        c0 = base_cfg(SEL_OFF); c1 = base_cfg(SEL_ADDR); c1.addr = 10'h011;
        p = build(10'h011, 8'h44, 36'h0, 1'b0);
        run_pkt(p, 1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 1'b1, "R6");
        run_pkt(p, 0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, "R6");

        // R11: idle cycles with stray start strobes change nothing.
        c0 = base_cfg(SEL_ADDR);
        p = build(10'h2A5, 8'h66, 36'h0, 1'b0);
        run_pkt(p, 0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 1'b1, "R11");

        // R10: abort part-way, then a complete packet.
        p2 = build(10'h2A5, 8'h99, 36'h0, 1'b0);
        send_part(p2, 0, 1'b1, 200);
        p = build(10'h2A5, 8'h67, 36'h0, 1'b0);
        run_pkt(p, 0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 1'b1, "R10");

        // R5: slot 81 accepted, slots 82 and beyond blocked.
        tick_start(1'b1);
        for (int i = 0; i < 79; i++) tick_start(1'b0);
        chk("R5", "bench slot count", exp_slot, 80);
        p = build(10'h2A5, 8'h01, 36'h0, 1'b0);
        run_pkt(p, 0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 1'b1, "R5");
        run_pkt(p, 0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, "R5");
        run_pkt(p, 0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 1'b1, "R5");
        run_pkt(p, 0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 1'b1, "R5");

        // Seeded random packets across modes, subframes and slots.
        for (int k = 0; k < 22; k++) begin
            flt_cfg_t c;
            logic [63:0] r64;
            logic [31:0] r;
            logic [9:0] a;
            logic [7:0] t;
            logic [35:0] e;
            bit first, bad, acc, half;
            int sf;
            r64 = {$urandom(), $urandom()};
            r = $urandom();
            c.addr = r[9:0];
            c.mode = sel_mode_e'(r[11:10]);
            c.grp_en = r[12];
            c.grp = r[16:13];
            c.half = r[17];
            c.ext_val = r64[35:0];
            r64 = {$urandom(), $urandom()};
            c.ext_mask = r64[35:0];
            sf = int'(r[18]);
            if (sf == 1) c1 = c; else c0 = c;
            r = $urandom();
            a = (r[1:0] != 2'b00) ? c.addr : r[11:2];
            t = r[13] ? 8'h00 : (r[14] ? 8'h3F : r[22:15]);
            r64 = {$urandom(), $urandom()};
            e = r[23] ? (c.ext_val ^ (r64[35:0] & ~c.ext_mask)) : r64[35:0];
            if (r[24]) e[3:0] = c.grp;
            bad = (r[26:25] == 2'b00);
            first = (r[28:27] == 2'b00) || (k == 0);
            p = build(a, t, e, bad);
            half = c.half && (c.mode != SEL_RAW);
            if (first) acc = exp_hit(c, p);
            else acc = exp_hit(c, p) && (exp_slot + 1 < 82);
            unc_exp = (c.mode == SEL_RAW) ? 4'd0 : r[31:28];
            run_pkt(p, sf, first, r[12], acc, half, r[31:28], !bad, "R1");
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule